// File: doc/BRIEF.md
# Cluster Configuration Registers with Relocatable Peripheral Window

This block holds the global configuration registers of a multicore cluster. A simple register-bus slave port reads and writes 64-bit registers by byte offset. Most registers are read-only identity words: a configuration word, the block's own base, a revision number, a second-level cache configuration word that reports bypass, and a status word that tells software whether a secondary power-control peripheral is attached.

One register is writable. It holds the physical base of the secondary peripheral's register window together with an enable flag. Software places that window anywhere in the physical address space on a 32 KB boundary and turns it on or off with a single write. A separate decode port takes a full physical address and raises a hit flag when the address falls inside the live, enabled window. The interconnect uses that flag to steer the access to the peripheral. A presence input tells the block whether the peripheral exists. Writes to the window register are dropped when it does not.

Top module: `cluster_cfg_regs`

## Requirements
- R1: After reset the window register reads 0, the window is disabled (`dec_hit` is 0 for any address), and `bus_rdata` is 0.
- R2: A write to offset 0x0088 while `periph_present` is 1 stores `bus_wdata` with every bit cleared except bit 0 (enable) and bits 47:15 (base), i.e. masked with 0x0000_FFFF_FFFF_8001; reading 0x0088 returns that stored value.
- R3: A write to offset 0x0088 while `periph_present` is 0 leaves the stored window value and the decode result unchanged.
- R4: A read of offset 0x00F0 returns 1 when `periph_present` is 1 in the read cycle and 0 when it is 0.
- R5: A read of offset 0x0130 returns 0x0000_0000_0010_0000 (only bit 20 set).
- R6: Reads of offset 0x0030, 0x0000 and 0x0008 return the parameters REV_ID (default 0x800), CFG_WORD (default 0) and SELF_BASE (default 0x1FBF_8000).
- R7: A read of any offset without a register returns 0; a write to any offset other than 0x0088 changes no register.
- R8: `dec_hit` is 1 exactly when the stored enable bit is 1 and `dec_addr[47:15]` equals the stored base bits 47:15; address bits 14:0 do not matter.
- R9: A write to 0x0088 changes `dec_hit` from the next clock edge on. In the write cycle itself the decoder still uses the old window, and base and enable change together.
- R10: Read data is registered: `bus_rdata` shows the addressed register one clock after `bus_rd` is high and holds its value while `bus_rd` is low. A read and a write of 0x0088 in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_present | input | 1 | Secondary peripheral is attached |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Read request |
| bus_addr | input | 16 | Register byte offset |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, one cycle after the request |
| dec_addr | input | 48 | Physical address to decode |
| dec_hit | output | 1 | Address falls in the enabled window |

## Verification
The decode port and a window register write can fall in the same cycle, and so can a read and a write of the window register. The bench holds a target address on `dec_addr` and drives a relocating write. It samples `dec_hit` just before the edge and expects the old window, then samples just after the edge and expects the new one. In a second case it asserts read and write of 0x0088 together and expects `bus_rdata` to carry the value from before the write.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int DATA_W = 64;
  localparam int OFS_W  = 16;

  localparam logic [OFS_W-1:0] OFS_CFG    = 16'h0000;
  localparam logic [OFS_W-1:0] OFS_SELF   = 16'h0008;
  localparam logic [OFS_W-1:0] OFS_REV    = 16'h0030;
  localparam logic [OFS_W-1:0] OFS_WIN    = 16'h0088;
  localparam logic [OFS_W-1:0] OFS_STATUS = 16'h00F0;
  localparam logic [OFS_W-1:0] OFS_L2     = 16'h0130;

  localparam int L2_BYPASS_BIT = 20;
endpackage

// File: rtl/win_base_reg.sv
module win_base_reg #(
  parameter int PA_W      = 48,
  parameter int WIN_ALIGN = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_sel,
  input  logic                       present,
  input  logic [ccr_pkg::DATA_W-1:0] wdata,
  output logic [ccr_pkg::DATA_W-1:0] win_q
);
  localparam int DW = ccr_pkg::DATA_W;
  localparam logic [DW-1:0] BASE_MASK =
    ((DW'(1) << PA_W) - DW'(1)) & ~((DW'(1) << WIN_ALIGN) - DW'(1));
  localparam logic [DW-1:0] KEEP_MASK = BASE_MASK | DW'(1);

  logic          load;
  logic [DW-1:0] win_d;

  always_comb begin
    load  = wr_sel & present;
    win_d = wdata & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    win_q <= '0;
    else if (load) win_q <= win_d;
  end

  p_drop_absent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && !present) |=> $stable(win_q));

  p_masked_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && present) |=> (win_q == ($past(wdata) & KEEP_MASK)));
endmodule

// File: rtl/win_decoder.sv
module win_decoder #(
  parameter int PA_W      = 48,
  parameter int WIN_ALIGN = 15
) (
  input  logic [ccr_pkg::DATA_W-1:0] win_q,
  input  logic [PA_W-1:0]            addr,
  output logic                       hit
);
  logic match;

  always_comb begin
    match = (win_q[PA_W-1:WIN_ALIGN] == addr[PA_W-1:WIN_ALIGN]);
    hit   = win_q[0] & match;
  end
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux #(
  parameter logic [ccr_pkg::DATA_W-1:0] REV_ID    = 64'h800,
  parameter logic [ccr_pkg::DATA_W-1:0] CFG_WORD  = 64'h0,
  parameter logic [ccr_pkg::DATA_W-1:0] SELF_BASE = 64'h1FBF_8000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd,
  input  logic [ccr_pkg::OFS_W-1:0]  addr,
  input  logic                       present,
  input  logic [ccr_pkg::DATA_W-1:0] win_q,
  output logic [ccr_pkg::DATA_W-1:0] rdata
);
  import ccr_pkg::*;

  logic [DATA_W-1:0] sel_d;

  always_comb begin
    sel_d = '0;
    case (addr)
      OFS_CFG:    sel_d = CFG_WORD;
      OFS_SELF:   sel_d = SELF_BASE;
      OFS_REV:    sel_d = REV_ID;
      OFS_WIN:    sel_d = win_q;
      OFS_STATUS: sel_d = {{(DATA_W-1){1'b0}}, present};
      OFS_L2:     sel_d[L2_BYPASS_BIT] = 1'b1;
      default:    sel_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= sel_d;
  end

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));

  p_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == OFS_STATUS) |=> (rdata == {{(DATA_W-1){1'b0}}, $past(present)}));

  p_l2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == OFS_L2) |=> ($countones(rdata) == 1 && rdata[L2_BYPASS_BIT]));
endmodule

// File: rtl/cluster_cfg_regs.sv
module cluster_cfg_regs #(
  parameter int                         PA_W      = 48,
  parameter int                         WIN_ALIGN = 15,
  parameter logic [ccr_pkg::DATA_W-1:0] REV_ID    = 64'h800,
  parameter logic [ccr_pkg::DATA_W-1:0] CFG_WORD  = 64'h0,
  parameter logic [ccr_pkg::DATA_W-1:0] SELF_BASE = 64'h1FBF_8000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       periph_present,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ccr_pkg::OFS_W-1:0]  bus_addr,
  input  logic [ccr_pkg::DATA_W-1:0] bus_wdata,
  output logic [ccr_pkg::DATA_W-1:0] bus_rdata,
  input  logic [PA_W-1:0]            dec_addr,
  output logic                       dec_hit
);
  import ccr_pkg::*;

  logic              win_wr_sel;
  logic [DATA_W-1:0] win_q;

  always_comb win_wr_sel = bus_wr & (bus_addr == OFS_WIN);

  win_base_reg #(.PA_W(PA_W), .WIN_ALIGN(WIN_ALIGN)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sel  (win_wr_sel),
    .present (periph_present),
    .wdata   (bus_wdata),
    .win_q   (win_q)
  );

  win_decoder #(.PA_W(PA_W), .WIN_ALIGN(WIN_ALIGN)) u_dec (
    .win_q (win_q),
    .addr  (dec_addr),
    .hit   (dec_hit)
  );

  cfg_read_mux #(.REV_ID(REV_ID), .CFG_WORD(CFG_WORD), .SELF_BASE(SELF_BASE)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd      (bus_rd),
    .addr    (bus_addr),
    .present (periph_present),
    .win_q   (win_q),
    .rdata   (bus_rdata)
  );

  p_disable_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr_sel && periph_present && !bus_wdata[0]) |=> !dec_hit);

  p_other_ofs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != OFS_WIN) |=> $stable(win_q));
endmodule

// File: tb/cluster_cfg_regs_test.sv
module cluster_cfg_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        periph_present = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [47:0] dec_addr = '0;
  logic        dec_hit;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cluster_cfg_regs uut (
    .clk(clk), .rst_n(rst_n), .periph_present(periph_present),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dec_addr(dec_addr), .dec_hit(dec_hit)
  );

  // op: 0 write, 1 read and compare, 2 decode and compare
  // fields: op[150:149] req[148:145] present[144] addr[143:128] data[127:64] exp[63:0]
  localparam int NV = 26;
  localparam logic [150:0] VEC [0:NV-1] = '{
    {2'd0, 4'd2,  1'b1, 16'h0088, 64'hABCD_1234_5678_FFFF, 64'h0},                    // R2
    {2'd1, 4'd2,  1'b1, 16'h0088, 64'h0, 64'h0000_1234_5678_8001},                    // R2
    {2'd2, 4'd8,  1'b1, 16'h0000, 64'h0000_1234_5678_8000, 64'h1},                    // R8
    {2'd2, 4'd8,  1'b1, 16'h0000, 64'h0000_1234_5678_FFFF, 64'h1},                    // R8
    {2'd2, 4'd8,  1'b1, 16'h0000, 64'h0000_1234_5679_0000, 64'h0},                    // R8
    {2'd2, 4'd8,  1'b1, 16'h0000, 64'h0000_1234_5678_7FFF, 64'h0},                    // R8
    {2'd0, 4'd3,  1'b0, 16'h0088, 64'h0, 64'h0},                                      // R3
    {2'd1, 4'd3,  1'b0, 16'h0088, 64'h0, 64'h0000_1234_5678_8001},                    // R3
    {2'd2, 4'd3,  1'b0, 16'h0000, 64'h0000_1234_5678_8000, 64'h1},                    // R3
    {2'd1, 4'd4,  1'b0, 16'h00F0, 64'h0, 64'h0},                                      // R4
    {2'd1, 4'd4,  1'b1, 16'h00F0, 64'h0, 64'h1},                                      // R4
    {2'd1, 4'd5,  1'b1, 16'h0130, 64'h0, 64'h0000_0000_0010_0000},                    // R5
    {2'd1, 4'd6,  1'b1, 16'h0030, 64'h0, 64'h800},                                    // R6
    {2'd1, 4'd6,  1'b1, 16'h0000, 64'h0, 64'h0},                                      // R6
    {2'd1, 4'd6,  1'b1, 16'h0008, 64'h0, 64'h1FBF_8000},                              // R6
    {2'd1, 4'd7,  1'b1, 16'h0010, 64'h0, 64'h0},                                      // R7
    {2'd0, 4'd7,  1'b1, 16'h0030, 64'hFFFF, 64'h0},                                   // R7
    {2'd1, 4'd7,  1'b1, 16'h0030, 64'h0, 64'h800},                                    // R7
    {2'd0, 4'd7,  1'b1, 16'h0010, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},                    // R7
    {2'd1, 4'd7,  1'b1, 16'h0088, 64'h0, 64'h0000_1234_5678_8001},                    // R7
    {2'd0, 4'd8,  1'b1, 16'h0088, 64'h0000_1234_5678_8000, 64'h0},                    // R8
    {2'd2, 4'd8,  1'b1, 16'h0000, 64'h0000_1234_5678_8000, 64'h0},                    // R8
    {2'd0, 4'd2,  1'b1, 16'h0088, 64'h1, 64'h0},                                      // R2
    {2'd2, 4'd8,  1'b1, 16'h0000, 64'h0000_0000_0000_1000, 64'h1},                    // R8
    {2'd2, 4'd8,  1'b1, 16'h0000, 64'h0000_0000_0000_8000, 64'h0},                    // R8
    {2'd1, 4'd2,  1'b1, 16'h0088, 64'h0, 64'h1}                                       // R2
  };

  task automatic check(input int req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [63:0] d, input logic p);
    @(negedge clk);
    periph_present = p; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, input logic p, output logic [63:0] d);
    @(negedge clk);
    periph_present = p; bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] rv;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check(1, bus_rdata, 64'h0);
    check(1, {63'b0, dec_hit}, 64'h0);
    rst_n = 1'b1;
    do_read(16'h0088, 1'b1, rv);
    check(1, rv, 64'h0);

    for (int i = 0; i < NV; i++) begin
      logic [150:0] v;
      v = VEC[i];
      case (v[150:149])
        2'd0: do_write(v[143:128], v[127:64], v[144]);
        2'd1: begin
          do_read(v[143:128], v[144], rv);
          check(int'(v[148:145]), rv, v[63:0]);
        end
        default: begin
          @(negedge clk);
          periph_present = v[144];
          dec_addr = v[111:64];
          #1;
          check(int'(v[148:145]), {63'b0, dec_hit}, v[63:0]);
        end
      endcase
    end

    // R9: decode during the write cycle uses the old window, new window after the edge
    do_write(16'h0088, 64'h0000_0000_0000_0001, 1'b1);
    @(negedge clk);
    dec_addr = 48'h0000_ABCD_0000;
    bus_addr = 16'h0088; bus_wdata = 64'h0000_0000_ABCD_0001; bus_wr = 1'b1;
    #1;
    check(9, {63'b0, dec_hit}, 64'h0);
    @(posedge clk); #1;
    check(9, {63'b0, dec_hit}, 64'h1);
    @(negedge clk);
    bus_wr = 1'b0;
    dec_addr = 48'h0;
    #1;
    check(9, {63'b0, dec_hit}, 64'h0);

    // R10: read and write of the window register in one cycle return the old value
    @(negedge clk);
    bus_addr = 16'h0088; bus_wdata = 64'h0000_0000_1111_8001; bus_wr = 1'b1; bus_rd = 1'b1;
    @(posedge clk); #1;
    check(10, bus_rdata, 64'h0000_0000_ABCD_0001);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    // R10: rdata holds while no read is requested
    bus_addr = 16'h0030;
    repeat (3) @(negedge clk);
    check(10, bus_rdata, 64'h0000_0000_ABCD_0001);
    do_read(16'h0088, 1'b1, rv);
    check(10, rv, 64'h0000_0000_1111_8001);

    // R1: reset in mid-run clears the window
    @(negedge clk);
    dec_addr = 48'h0000_1111_8000;
    #1;
    check(1, {63'b0, dec_hit}, 64'h1);
    rst_n = 1'b0;
    #1;
    check(1, {63'b0, dec_hit}, 64'h0);
    check(1, bus_rdata, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    do_read(16'h0088, 1'b1, rv);
    check(1, rv, 64'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule